// File: doc/BRIEF.md
# Address-masked GPIO bank

This block is a bank of eight general-purpose pins attached to a small synchronous byte-wide register bus. One register sets each pin's direction: a 1 makes the pin an output and a 0 makes it an input. Software reads this register back, so it can read it, change a single bit and write it back. Pin levels are handled through a data window that lies below the direction register. Inside that window the offset does more than locate a register. Offset bits [9:2] form a per-pin mask, and bit n+2 selects pin n.

A write to the data window updates only the output latches whose mask bit is set. Each of those latches takes the matching bit of the write data. Any subset of pins can therefore be changed in a single atomic access, with no read-modify-write. A read from the data window returns the current pin values ANDed with the mask. An output pin reports its latch. An input pin reports its pad level after a two-stage synchronizer.

Each pad output enable follows its direction bit, and each pad output level follows its latch. To bring a pin up as an output, software writes the direction bit first and then writes the level through the masked window.

Top module: `gpio_bank`

## Requirements
- R1: While reset is high and in the cycle after it, the direction register is 0, so every pin is an input. All output latches are 0, `pad_oe` is 0, `pad_out` is 0 and `bus_rdata` is 0.
- R2: A write at offset 0x400 loads `bus_wdata` into the direction register. Bit n of that register is 1 when pin n is an output and 0 when it is an input. `pad_oe` equals the direction register in the cycle after the write. A read at offset 0x400 returns the direction register.
- R3: A write at any offset below 0x400 uses offset bits [9:2] as a mask, with bit n+2 selecting pin n. Output latch n takes `bus_wdata[n]` only when its mask bit is 1. Every other latch keeps its value.
- R4: A read at an offset below 0x400 returns the pin values ANDed with the mask from offset bits [9:2]. A read at offset 4<<n is non-zero exactly when pin n is high.
- R5: The value read for a pin depends on its direction. For an output pin it is the output latch. For an input pin it is `pad_in` after two synchronizer flops: a change on the pad is not seen by a read registered at the second clock edge after the change, and is seen from the third edge onward.
- R6: A write at an offset above 0x400 changes neither the direction register nor any latch. A read at such an offset returns 0.
- R7: `pad_out` equals the output latches at all times, whatever the direction. A latch can therefore be written while its pin is an input, and the level appears on the pad once the pin becomes an output.
- R8: Read data appears on `bus_rdata` one cycle after the read access. In any cycle that follows a cycle without a read access, `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 11 | Byte offset (PINS+3 bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output levels |

## Verification
The bench builds the block with PINS=8 and SYNC_STAGES=2. This puts the direction register at offset 0x400 and gives an 11-bit offset, so all 256 mask patterns in the data window can be reached, along with the offset space above the direction register. Random offsets cover masks that select no pins, some pins or all pins, under mixed directions. Directed accesses probe single-pin offsets 4<<n, the synchronizer delay, and latches written while their pin is an input.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Kind of bus access decoded from strobe and offset.
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2,
        ACC_VOID = 2'd3
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t kind;
        logic      wr;
    } acc_t;

    // Offsets below the direction register form the masked data window.
    function automatic acc_kind_t classify(input logic sel,
                                           input logic [31:0] off,
                                           input logic [31:0] dir_off);
        if (!sel)
            return ACC_NONE;
        else if (off < dir_off)
            return ACC_DATA;
        else if (off == dir_off)
            return ACC_DIR;
        else
            return ACC_VOID;
    endfunction

    function automatic logic is_write(input acc_t a, input acc_kind_t k);
        return (a.kind == k) && a.wr;
    endfunction

    function automatic logic is_read(input acc_t a, input acc_kind_t k);
        return (a.kind == k) && !a.wr;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  acc_t            acc,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] lat_q
);
    logic dir_wr;
    logic dat_wr;

    assign dir_wr = is_write(acc, ACC_DIR);
    assign dat_wr = is_write(acc, ACC_DATA);

    always_ff @(posedge clk) begin
        if (rst)         dir_q <= '0;
        else if (dir_wr) dir_q <= wdata;
    end

    // One latch per pin, each gated by its own mask bit.
    for (genvar i = 0; i < PINS; i++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)                     lat_q[i] <= 1'b0;
            else if (dat_wr && mask[i])  lat_q[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/gpio_rdpath.sv
module gpio_rdpath
    import gpio_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  acc_t            acc,
    input  logic [PINS-1:0] mask,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] lat_q,
    input  logic [PINS-1:0] sync_in,
    output logic [PINS-1:0] rdata
);
    logic [PINS-1:0] level;
    logic [PINS-1:0] rd_next;

    for (genvar i = 0; i < PINS; i++) begin : g_level
        assign level[i] = dir_q[i] ? lat_q[i] : sync_in[i];
    end

    always_comb begin
        if (is_read(acc, ACC_DATA))
            rd_next = level & mask;
        else if (is_read(acc, ACC_DIR))
            rd_next = dir_q;
        else
            rd_next = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_next;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int PINS        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = PINS + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out
);
    localparam logic [31:0] DIR_OFF = 32'(4) << PINS;

    acc_t            acc;
    logic [PINS-1:0] mask;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] lat_q;
    logic [PINS-1:0] sync_in;

    assign acc.kind = classify(bus_sel, 32'(bus_addr), DIR_OFF);
    assign acc.wr   = bus_we;
    assign mask     = bus_addr[PINS+1:2];

    gpio_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (sync_in)
    );

    gpio_regs #(.PINS(PINS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .mask  (mask),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_rdpath #(.PINS(PINS)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .mask    (mask),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .sync_in (sync_in),
        .rdata   (bus_rdata)
    );

    assign pad_oe  = dir_q;
    assign pad_out = lat_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int PINS   = 8,
    parameter int ADDR_W = PINS + 3
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out
);
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(4 << PINS);

    logic            primed;
    logic            c_dat_wr, c_dir_wr, c_dir_rd, c_void_wr, c_any_rd;
    logic [PINS-1:0] c_mask;

    always_ff @(posedge clk) primed <= !rst;

    assign c_mask    = bus_addr[PINS+1:2];
    assign c_dat_wr  = bus_sel && bus_we && (bus_addr < DIR_A);
    assign c_dir_wr  = bus_sel && bus_we && (bus_addr == DIR_A);
    assign c_dir_rd  = bus_sel && !bus_we && (bus_addr == DIR_A);
    assign c_void_wr = bus_sel && bus_we && (bus_addr > DIR_A);
    assign c_any_rd  = bus_sel && !bus_we;

    assert_reset_state_R1: assert property (@(posedge clk)
        $fell(rst) |-> (pad_oe == '0) && (pad_out == '0) && (bus_rdata == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        primed && c_dir_wr |=> pad_oe == $past(bus_wdata));

    assert_dir_read_R2: assert property (@(posedge clk) disable iff (rst)
        primed && c_dir_rd && !c_dir_wr |=> bus_rdata == $past(pad_oe));

    assert_masked_write_R3: assert property (@(posedge clk) disable iff (rst)
        primed && c_dat_wr |=>
            pad_out == (($past(pad_out) & ~$past(c_mask)) | ($past(bus_wdata) & $past(c_mask))));

    assert_void_write_R6: assert property (@(posedge clk) disable iff (rst)
        primed && c_void_wr |=> (pad_out == $past(pad_out)) && (pad_oe == $past(pad_oe)));

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        primed && !c_dat_wr |=> pad_out == $past(pad_out));

    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
        primed && !c_any_rd |=> bus_rdata == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
    localparam int PINS = 8;
    localparam int AW   = PINS + 3;
    localparam logic [AW-1:0] DIR_A = AW'(4 << PINS);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [PINS-1:0] bus_wdata = '0, pad_in = '0;
    logic [PINS-1:0] bus_rdata, pad_oe, pad_out;

    int total = 0, bad = 0;
    logic [PINS-1:0] dir_m = '0, lat_m = '0, pad_m = '0;

    always #2.5 clk = ~clk;

    gpio_bank #(.PINS(PINS), .SYNC_STAGES(2)) i_gpio_bank (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out));

    function automatic logic [PINS-1:0] addr_mask(input logic [AW-1:0] a);
        return a[PINS+1:2];
    endfunction

    function automatic logic [PINS-1:0] exp_read(input logic [AW-1:0] a);
        if (a < DIR_A)       return ((dir_m & lat_m) | (~dir_m & pad_m)) & addr_mask(a);
        else if (a == DIR_A) return dir_m;
        else                 return '0;
    endfunction

    task automatic check(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [PINS-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (a < DIR_A)       lat_m = (lat_m & ~addr_mask(a)) | (d & addr_mask(a));
        else if (a == DIR_A) dir_m = d;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [PINS-1:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a);
        logic [PINS-1:0] v;
        logic [PINS-1:0] e;
        e = exp_read(a);
        rd(a, v);
        check(tag, v, e);
    endtask

    task automatic set_pad(input logic [PINS-1:0] p);
        @(negedge clk);
        pad_in = p; pad_m = p;
        repeat (2) @(negedge clk);
    endtask

    task automatic pins_chk(input string tag);
        check({tag, " oe"}, pad_oe, dir_m);
        check({tag, " out"}, pad_out, lat_m);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [PINS-1:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (4) @(negedge clk);
        check("R1 reset oe", pad_oe, '0);
        check("R1 reset out", pad_out, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset rdata", bus_rdata, '0);
        rd_chk("R1 dir reads zero", DIR_A);

        // R2 direction write and readback
        wr(DIR_A, 8'hA5);
        pins_chk("R2 dir write");
        rd_chk("R2 dir readback", DIR_A);

        // R3 masked writes: single pin, none, all
        wr(AW'(4 << 0), 8'hFF);
        pins_chk("R3 pin0 only");
        wr(AW'(0), 8'hFF);
        pins_chk("R3 empty mask");
        wr(AW'(8'hFF << 2), 8'h3C);
        pins_chk("R3 full mask");
        wr(AW'(8'h0F << 2), 8'hF0);
        pins_chk("R3 low nibble mask");

        // R4 single-pin reads at 4<<n
        for (int n = 0; n < PINS; n++) rd_chk("R4 single pin read", AW'(4 << n));

        // R5 synchronizer delay, all pins input
        wr(DIR_A, 8'h00);
        set_pad(8'h00);
        @(negedge clk);
        pad_in = 8'h5A;
        rd(AW'(8'hFF << 2), v);
        check("R5 pad not yet visible", v, 8'h00);
        pad_m = 8'h5A;
        rd_chk("R5 pad visible after sync", AW'(8'hFF << 2));

        // R7 latch written while input, then enabled
        wr(AW'(8'h80 << 2), 8'h80);
        check("R7 out while input", pad_out, lat_m);
        wr(DIR_A, 8'h80);
        pins_chk("R7 enabled");
        rd_chk("R5 output reads latch", AW'(8'h80 << 2));

        // R6 ignored offsets above direction register
        wr(DIR_A + 1, 8'hFF);
        pins_chk("R6 ignored write +1");
        wr({AW{1'b1}}, 8'h00);
        pins_chk("R6 ignored write top");
        rd_chk("R6 read above is zero", DIR_A + 4);

        // R8 idle after read returns zero
        rd(DIR_A, v);
        @(negedge clk);
        check("R8 idle rdata zero", bus_rdata, '0);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            logic [AW-1:0] a;
            op = $urandom_range(0, 9);
            a  = AW'($urandom_range(0, DIR_A - 1));
            case (op)
                0:       wr(DIR_A, PINS'($urandom));
                1, 2, 3: begin wr(a, PINS'($urandom)); pins_chk("R3 random write"); end
                4:       set_pad(PINS'($urandom));
                5:       begin wr(AW'($urandom_range(DIR_A + 1, (1 << AW) - 1)), PINS'($urandom));
                               pins_chk("R6 random ignored"); end
                6:       rd_chk("R6 random read above", AW'($urandom_range(DIR_A + 1, (1 << AW) - 1)));
                7:       rd_chk("R2 random dir read", DIR_A);
                default: rd_chk("R4 random masked read", a);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule